// File: doc/BRIEF.md
# Display Channel I2C Slave with Clock Stretching

This block is a byte-level I2C slave for the display data channel of a monitor. A small CPU services it through four byte-wide registers. The block samples SCL and SDA with the system clock and finds START and STOP conditions, repeated STARTs included. After each START it takes in an address byte and compares it with a fixed address and with one address that software programs. On a match it acknowledges the address and flags an address interrupt. It then moves data one byte at a time in the direction that software selects.

At the end of every byte, on the falling SCL edge that closes the ninth clock, the block raises a per-byte interrupt and holds SCL low. The CPU ends this wait by writing the data register. In receive mode that write is a dummy zero. In transmit mode it is the next byte to send. Both bus lines are open-drain outputs: each output is an enable that pulls its line low.

Register map (2-bit index): 0 = data, 1 = own address in bits 7:1, 2 = control (bit0 transmit select, bit1 address-interrupt enable), 3 = status (bit0 start seen, bit1 address hit, bit2 byte done, bit3 master acknowledge bit; writing 1 to bits 2:0 clears those bits).

Top module: `ddc_i2c_slave`

## Requirements
- R1: An SDA fall while SCL is high sets status bit0. The bit stays 1 until software writes 1 to status bit0.
- R2: A START that arrives in the middle of a transfer, with no STOP before it, restarts address reception. The next byte is compared as an address again.
- R3: After each START the first byte is shifted in MSB first, and the whole byte, R/W bit included, appears in data register 0.
- R4: An address whose bits 7:1 equal 0x50 (byte 0xA0/0xA1) or equal register 1 bits 7:1 is acknowledged: SDA is pulled low during the ninth clock, and status bit1 is set.
- R5: intr_addr_o is high only while status bit1 is set and control bit1 is set. If control bit1 is set after the match, the output rises then.
- R6: On an address mismatch there is no acknowledge, no flag and no stretch. Every later byte is ignored until the next START.
- R7: Control bit0 selects the direction: 1 means transmit (the master reads), 0 means receive (the master writes).
- R8: In receive mode each data byte is acknowledged low on the ninth clock and stored in data register 0.
- R9: On the falling SCL edge that ends the ninth clock of every byte, status bit2 and intr_byte_o are set, and scl_oe_o holds SCL low.
- R10: Any write to data register 0 releases the held SCL. In transmit mode the written byte is then sent MSB first.
- R11: In transmit mode the SDA level that the master drives during the ninth clock is stored in status bit3 (0 means ACK).
- R12: An SDA rise while SCL is high (STOP) returns the block to idle with both lines released. Clocks that arrive after it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge or data 0) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| intr_addr_o | output | 1 | Address-match interrupt |
| intr_byte_o | output | 1 | Per-byte interrupt |

## Verification
The bench goes after the transmit-mode bit timing. A design that releases the last data bit on the rising edge of the eighth clock instead of after its falling edge would create a false STOP and drop the transfer. It checks that a repeated START after a NACKed read is decoded as a new address; a design that kept counting bits would acknowledge at the wrong clock. A mismatched address followed by a byte that looks like 0xA0 exposes a design that goes on decoding after a mismatch. A late change to the interrupt enable exposes an address interrupt that was latched instead of gated.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned REG_AW    = 2;

  localparam logic [REG_AW-1:0] REG_DATA = 2'd0;
  localparam logic [REG_AW-1:0] REG_OWN  = 2'd1;
  localparam logic [REG_AW-1:0] REG_CTRL = 2'd2;
  localparam logic [REG_AW-1:0] REG_STAT = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } bus_state_e;
endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/ddc_bus_fsm.sv
module ddc_bus_fsm
  import ddc_pkg::*;
#(
  parameter logic [6:0] FIXED_ADDR = 7'h50
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_lvl_i,
  input  logic                 scl_rise_i,
  input  logic                 scl_fall_i,
  input  logic                 sda_lvl_i,
  input  logic                 sda_rise_i,
  input  logic                 sda_fall_i,
  input  logic [6:0]           own_addr_i,
  input  logic                 trx_i,
  input  logic                 release_i,
  input  logic [BYTE_BITS-1:0] tx_byte_i,
  output logic                 start_o,
  output logic                 addr_hit_o,
  output logic                 rx_load_o,
  output logic [BYTE_BITS-1:0] rx_byte_o,
  output logic                 byte_done_o,
  output logic                 rxak_load_o,
  output logic                 rxak_o,
  output logic                 scl_oe_o,
  output logic                 sda_oe_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_BITS + 1);

  bus_state_e           state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [BYTE_BITS-1:0] rx_sr_q, tx_sr_q;
  logic                 ack_q, ack_ph_q, stretch_q;

  logic start_ev, stop_ev, active, match, eighth_fall, ninth_fall, tx_mode, tx_drive;

  assign start_ev    = sda_fall_i & scl_lvl_i;
  assign stop_ev     = sda_rise_i & scl_lvl_i;
  assign active      = (state_q == ST_ADDR) || (state_q == ST_DATA);
  assign match       = (rx_sr_q[7:1] == FIXED_ADDR) || (rx_sr_q[7:1] == own_addr_i);
  assign eighth_fall = active & scl_fall_i & (cnt_q == CNT_LAST) & ~ack_ph_q;
  assign ninth_fall  = active & scl_fall_i & (cnt_q == CNT_ACK);
  assign tx_mode     = (state_q == ST_DATA) & trx_i;
  // hold the last bit through the eighth low phase, never change SDA under SCL high
  assign tx_drive    = tx_mode & ~stretch_q & ~ack_ph_q & (cnt_q <= CNT_LAST) & ~tx_sr_q[BYTE_BITS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rx_sr_q   <= '0;
      tx_sr_q   <= '1;
      ack_q     <= 1'b0;
      ack_ph_q  <= 1'b0;
      stretch_q <= 1'b0;
    end else if (start_ev) begin
      state_q   <= ST_ADDR;
      cnt_q     <= '0;
      ack_q     <= 1'b0;
      ack_ph_q  <= 1'b0;
      stretch_q <= 1'b0;
    end else if (stop_ev) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      ack_q     <= 1'b0;
      ack_ph_q  <= 1'b0;
      stretch_q <= 1'b0;
    end else begin
      if (active && scl_rise_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q < CNT_LAST) rx_sr_q <= {rx_sr_q[BYTE_BITS-2:0], sda_lvl_i};
      end
      if (eighth_fall) begin
        ack_ph_q <= 1'b1;
        if (state_q == ST_ADDR && !match) state_q <= ST_SKIP;
        else ack_q <= (state_q == ST_ADDR) | ~trx_i;
      end
      if (ninth_fall) begin
        ack_q     <= 1'b0;
        ack_ph_q  <= 1'b0;
        stretch_q <= 1'b1;
        cnt_q     <= '0;
        if (state_q == ST_ADDR) state_q <= ST_DATA;
      end
      if (tx_mode && scl_fall_i && cnt_q != '0 && cnt_q < CNT_LAST)
        tx_sr_q <= {tx_sr_q[BYTE_BITS-2:0], 1'b1};
      if (stretch_q && release_i) begin
        stretch_q <= 1'b0;
        tx_sr_q   <= tx_byte_i;
      end
    end
  end

  assign start_o     = start_ev;
  assign addr_hit_o  = eighth_fall & (state_q == ST_ADDR) & match;
  assign rx_load_o   = eighth_fall & (((state_q == ST_ADDR) & match) | ((state_q == ST_DATA) & ~trx_i));
  assign rx_byte_o   = rx_sr_q;
  assign byte_done_o = ninth_fall;
  assign rxak_load_o = tx_mode & scl_rise_i & (cnt_q == CNT_LAST) & ~start_ev & ~stop_ev;
  assign rxak_o      = sda_lvl_i;
  assign scl_oe_o    = stretch_q;
  assign sda_oe_o    = ack_q | tx_drive;

  assert_skip_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> (!sda_oe_o && !scl_oe_o));

  assert_stretch_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_oe_o && !release_i && !start_ev && !stop_ev) |=> scl_oe_o);

  assert_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_oe_o && release_i) |=> !scl_oe_o);

  assert_stop_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_ev && !start_ev) |=> (!scl_oe_o && !sda_oe_o));

  assert_ack_low_scl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_q) |-> !scl_lvl_i || start_ev || stop_ev || $past(stop_ev) || $past(start_ev));
endmodule

// File: rtl/ddc_regs.sv
module ddc_regs
  import ddc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [REG_AW-1:0]    addr_i,
  input  logic [BYTE_BITS-1:0] wdata_i,
  output logic [BYTE_BITS-1:0] rdata_o,
  input  logic                 start_i,
  input  logic                 addr_hit_i,
  input  logic                 rx_load_i,
  input  logic [BYTE_BITS-1:0] rx_byte_i,
  input  logic                 byte_done_i,
  input  logic                 rxak_load_i,
  input  logic                 rxak_i,
  output logic [6:0]           own_addr_o,
  output logic                 trx_o,
  output logic                 release_o,
  output logic                 intr_addr_o,
  output logic                 intr_byte_o
);
  logic [BYTE_BITS-1:0] data_q;
  logic [6:0]           own_q;
  logic                 trx_q, ie_q, start_f, addr_f, byte_f, rxak_q;
  logic                 wr_data, wr_own, wr_ctrl, wr_stat;

  assign wr_data = we_i && addr_i == REG_DATA;
  assign wr_own  = we_i && addr_i == REG_OWN;
  assign wr_ctrl = we_i && addr_i == REG_CTRL;
  assign wr_stat = we_i && addr_i == REG_STAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      own_q   <= '0;
      trx_q   <= 1'b0;
      ie_q    <= 1'b0;
      start_f <= 1'b0;
      addr_f  <= 1'b0;
      byte_f  <= 1'b0;
      rxak_q  <= 1'b0;
    end else begin
      if (rx_load_i)    data_q <= rx_byte_i;
      else if (wr_data) data_q <= wdata_i;
      if (wr_own) own_q <= wdata_i[7:1];
      if (wr_ctrl) begin
        trx_q <= wdata_i[0];
        ie_q  <= wdata_i[1];
      end
      if (start_i)                     start_f <= 1'b1;
      else if (wr_stat && wdata_i[0])  start_f <= 1'b0;
      if (addr_hit_i)                  addr_f <= 1'b1;
      else if (wr_stat && wdata_i[1])  addr_f <= 1'b0;
      if (byte_done_i)                             byte_f <= 1'b1;
      else if ((wr_stat && wdata_i[2]) || wr_data) byte_f <= 1'b0;
      if (rxak_load_i) rxak_q <= rxak_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_DATA: rdata_o = data_q;
      REG_OWN:  rdata_o = {own_q, 1'b0};
      REG_CTRL: rdata_o = {6'd0, ie_q, trx_q};
      default:  rdata_o = {4'd0, rxak_q, byte_f, addr_f, start_f};
    endcase
  end

  assign own_addr_o  = own_q;
  assign trx_o       = trx_q;
  assign release_o   = wr_data;
  assign intr_addr_o = addr_f & ie_q;
  assign intr_byte_o = byte_f;

  assert_start_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_f && !(wr_stat && wdata_i[0])) |=> start_f);

  assert_inta_raise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_hit_i && ie_q && !wr_ctrl) |=> intr_addr_o);

  assert_byte_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i |=> intr_byte_o);
endmodule

// File: rtl/ddc_i2c_slave.sv
module ddc_i2c_slave
  import ddc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [6:0]  FIXED_ADDR  = 7'h50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              intr_addr_o,
  output logic              intr_byte_o
);
  localparam int unsigned N_LINES = 2; // 0 = SCL, 1 = SDA

  logic [N_LINES-1:0] raw, lvl, rise, fall;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    ddc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw[g]),
      .lvl_o  (lvl[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  logic [6:0]           own_addr;
  logic                 trx, release_w, start_w, addr_hit, rx_load, byte_done, rxak_load, rxak;
  logic [BYTE_BITS-1:0] rx_byte;

  ddc_bus_fsm #(.FIXED_ADDR(FIXED_ADDR)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_lvl_i   (lvl[0]),
    .scl_rise_i  (rise[0]),
    .scl_fall_i  (fall[0]),
    .sda_lvl_i   (lvl[1]),
    .sda_rise_i  (rise[1]),
    .sda_fall_i  (fall[1]),
    .own_addr_i  (own_addr),
    .trx_i       (trx),
    .release_i   (release_w),
    .tx_byte_i   (reg_wdata_i),
    .start_o     (start_w),
    .addr_hit_o  (addr_hit),
    .rx_load_o   (rx_load),
    .rx_byte_o   (rx_byte),
    .byte_done_o (byte_done),
    .rxak_load_o (rxak_load),
    .rxak_o      (rxak),
    .scl_oe_o    (scl_oe_o),
    .sda_oe_o    (sda_oe_o)
  );

  ddc_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .start_i     (start_w),
    .addr_hit_i  (addr_hit),
    .rx_load_i   (rx_load),
    .rx_byte_i   (rx_byte),
    .byte_done_i (byte_done),
    .rxak_load_i (rxak_load),
    .rxak_i      (rxak),
    .own_addr_o  (own_addr),
    .trx_o       (trx),
    .release_o   (release_w),
    .intr_addr_o (intr_addr_o),
    .intr_byte_o (intr_byte_o)
  );
endmodule

// File: tb/ddc_i2c_slave_tb_top.sv
module ddc_i2c_slave_tb_top;
  localparam int Q = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe_o, sda_oe_o, intr_addr_o, intr_byte_o;
  logic reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'd0;
  logic [7:0] reg_rdata_o;
  logic scl_line, sda_line;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] exp_q[$];

  assign scl_line = !(m_scl_low || scl_oe_o);
  assign sda_line = !(m_sda_low || sda_oe_o);

  always #10 clk_i = ~clk_i;

  ddc_i2c_slave dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .intr_addr_o(intr_addr_o), .intr_byte_o(intr_byte_o)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
      report();
    end
  end

  // monitor: data register content at every per-byte interrupt (R3, R8)
  always @(posedge intr_byte_o) begin
    @(negedge clk_i); #2;
    if (exp_q.size() == 0) chk("R3 unexpected byte interrupt", 32'(reg_rdata_o), 32'hxx);
    else chk("R3/R8 data register", 32'(reg_rdata_o), 32'(exp_q.pop_front()));
  end

  task automatic wait_q(); repeat (Q) @(negedge clk_i); endtask
  task automatic wait_scl_high(); while (!scl_line) @(negedge clk_i); endtask

  task automatic start_cond();
    m_sda_low = 1'b0; wait_q();
    m_scl_low = 1'b0; wait_scl_high(); wait_q();
    m_sda_low = 1'b1; wait_q();
    m_scl_low = 1'b1; wait_q();
  endtask

  task automatic stop_cond();
    m_sda_low = 1'b1; wait_q();
    m_scl_low = 1'b0; wait_scl_high(); wait_q();
    m_sda_low = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; wait_q();
      m_scl_low = 1'b0; wait_scl_high(); wait_q();
      m_scl_low = 1'b1; wait_q();
    end
    m_sda_low = 1'b0; wait_q();
    m_scl_low = 1'b0; wait_scl_high(); wait_q();
    ack = sda_line;
    m_scl_low = 1'b1; wait_q();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nack);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wait_q();
      m_scl_low = 1'b0; wait_scl_high(); wait_q();
      b[i] = sda_line;
      m_scl_low = 1'b1;
    end
    wait_q();
    m_sda_low = ~nack; wait_q();
    m_scl_low = 1'b0; wait_scl_high(); wait_q();
    m_scl_low = 1'b1; wait_q();
    m_sda_low = 1'b0;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 1'b0; reg_addr_i = 2'd0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i); reg_addr_i = a; #1; d = reg_rdata_o; reg_addr_i = 2'd0;
  endtask

  // CPU service of a held byte: check stretch, write data register, check release
  task automatic service(input logic [7:0] d);
    @(negedge clk_i);
    chk("R9 scl held", 32'(scl_oe_o), 32'd1);
    chk("R9 byte interrupt", 32'(intr_byte_o), 32'd1);
    reg_wr(2'd0, d);
    @(negedge clk_i);
    chk("R10 scl released", 32'(scl_oe_o), 32'd0);
  endtask

  initial begin
    logic ack;
    logic [7:0] s, b;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 reset scl_oe", 32'(scl_oe_o), 32'd0);
    chk("R12 reset sda_oe", 32'(sda_oe_o), 32'd0);
    chk("R5 reset intr_addr", 32'(intr_addr_o), 32'd0);
    reg_rd(2'd3, s); chk("R1 reset status", 32'(s), 32'd0);

    reg_wr(2'd1, 8'h6E);
    reg_wr(2'd2, 8'h02);

    // write transfer to the fixed address
    start_cond();
    reg_rd(2'd3, s); chk("R1 start bit", 32'(s[0]), 32'd1);
    exp_q.push_back(8'hA0); send_byte(8'hA0, ack);
    chk("R4 fixed address ack", 32'(ack), 32'd0);
    chk("R5 intr_addr", 32'(intr_addr_o), 32'd1);
    reg_rd(2'd3, s); chk("R4 address flag", 32'(s[1]), 32'd1);
    service(8'h00);
    exp_q.push_back(8'h3C); send_byte(8'h3C, ack); chk("R8 data ack", 32'(ack), 32'd0);
    service(8'h00);
    exp_q.push_back(8'hC5); send_byte(8'hC5, ack); chk("R8 data ack", 32'(ack), 32'd0);
    reg_rd(2'd3, s); chk("R1 start bit sticky", 32'(s[0]), 32'd1);
    service(8'h00);
    stop_cond();
    @(negedge clk_i);
    chk("R12 stop scl", 32'(scl_oe_o), 32'd0);
    chk("R12 stop sda", 32'(sda_oe_o), 32'd0);
    reg_wr(2'd3, 8'h07);
    reg_rd(2'd3, s); chk("R1 cleared", 32'(s[2:0]), 32'd0);

    // clocks after STOP with no START are ignored
    m_scl_low = 1'b1; wait_q();
    send_byte(8'hA0, ack); chk("R12 no ack after stop", 32'(ack), 32'd1);
    chk("R12 no byte interrupt", 32'(intr_byte_o), 32'd0);
    stop_cond();

    // read from the programmable address
    start_cond();
    exp_q.push_back(8'h6F); send_byte(8'h6F, ack);
    chk("R4 own address ack", 32'(ack), 32'd0);
    reg_wr(2'd2, 8'h03);
    exp_q.push_back(8'h5A); service(8'h5A);
    recv_byte(b, 1'b0); chk("R10 tx byte", 32'(b), 32'h5A);
    reg_rd(2'd3, s); chk("R11 master ack", 32'(s[3]), 32'd0);
    exp_q.push_back(8'h81); service(8'h81);
    recv_byte(b, 1'b1); chk("R7 tx byte", 32'(b), 32'h81);
    reg_rd(2'd3, s); chk("R11 master nack", 32'(s[3]), 32'd1);
    service(8'hFF);

    // repeated START, direction back to receive
    start_cond();
    reg_wr(2'd2, 8'h02);
    exp_q.push_back(8'hA0); send_byte(8'hA0, ack);
    chk("R2 address after repeated start", 32'(ack), 32'd0);
    service(8'h00);
    exp_q.push_back(8'h11); send_byte(8'h11, ack); chk("R7 receive ack", 32'(ack), 32'd0);
    service(8'h00);
    stop_cond();

    // address mismatch
    reg_wr(2'd3, 8'h07);
    start_cond();
    send_byte(8'h42, ack); chk("R6 no ack on mismatch", 32'(ack), 32'd1);
    chk("R6 no intr_addr", 32'(intr_addr_o), 32'd0);
    chk("R6 no stretch", 32'(scl_oe_o), 32'd0);
    send_byte(8'hA0, ack); chk("R6 later byte ignored", 32'(ack), 32'd1);
    chk("R6 no byte interrupt", 32'(intr_byte_o), 32'd0);
    reg_rd(2'd3, s); chk("R6 flags clear", 32'(s[2:1]), 32'd0);
    stop_cond();

    // interrupt enable gating
    reg_wr(2'd2, 8'h00);
    reg_wr(2'd3, 8'h07);
    start_cond();
    exp_q.push_back(8'hA1); send_byte(8'hA1, ack); chk("R4 A1 ack", 32'(ack), 32'd0);
    chk("R5 gated intr_addr", 32'(intr_addr_o), 32'd0);
    reg_rd(2'd3, s); chk("R5 flag still set", 32'(s[1]), 32'd1);
    reg_wr(2'd2, 8'h02);
    @(negedge clk_i); chk("R5 late enable", 32'(intr_addr_o), 32'd1);
    service(8'hFF);
    stop_cond();

    repeat (5) @(negedge clk_i);
    chk("R3 all bytes seen", 32'(exp_q.size()), 32'd0);
    report();
  end
endmodule